// File: doc/BRIEF.md
# Four-Level Priority Interrupt Controller

This block watches four level-sensitive interrupt request lines and decides which one the processor services next. Level 0 has the highest priority and level 3 the lowest. The lines are sampled once per processor cycle, on the clock edge that opens phase 0 of a cycle of `PHASES` clocks. A 4-bit mask register disables levels: a mask bit of 1 blocks its level. The block reports whether any unmasked request is pending, and which level wins.

When a request wins and no acknowledge is running, the block asks the bus interface for an acknowledge access. The bus interface answers by raising its sync strobe. For as long as sync stays high, the block raises its acknowledge strobe and drives a 4-bit code on the data lines. For level L, the code has bits L through 3 set. When sync falls, the code is loaded as the new mask, so only strictly higher-priority levels can interrupt the service routine. Software can reload the mask through a separate write port.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Reset leaves the block with every level enabled (mask 0000), with pending_o, level_o, ack_req_o, iack_o and dal_oe_o all 0, and with no acknowledge in progress, even if reset arrives in the middle of one.
- R2: The request lines are captured only at the edge that starts phase 0 of a processor cycle. A request that rises and falls between two such edges has no effect on pending_o or ack_req_o.
- R3: pending_o is 1 exactly when the last captured request vector holds a 1 at a position whose mask bit is 0 (mask bit 1 = level disabled, bit i = level i).
- R4: On the phase-1 edge while idle, level_o takes the lowest-numbered level among the unmasked captured requests, or 0 when none is pending.
- R5: On the phase-1 edge while idle with pending_o high, ack_req_o rises. It then stays high until bus_sync_i is seen high at a clock edge.
- R6: iack_o follows bus_sync_i while an acknowledge is requested or running. It is 0 whenever no acknowledge is in progress, so sync pulses at other times are ignored.
- R7: While iack_o is high, dal_oe_o is high and dal_code_o carries the code of the held level L, with bit i set when i >= L. Otherwise dal_oe_o is 0 and dal_code_o is 0000.
- R8: The first clock edge during an acknowledge at which bus_sync_i is low ends the acknowledge. At that edge the code is written into the mask and the block returns to idle.
- R9: While an acknowledge is requested or running, level_o holds its value even when new requests are captured.
- R10: A mask write is loaded at the next clock edge, and pending_o follows it at once. The new mask is first used to start an acknowledge at the next phase-1 edge.
- R11: A mask write at the same edge that ends an acknowledge is dropped, and the acknowledge code is kept.
- R12: With all four mask bits set, no request starts an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | 4 | Level-sensitive request lines, bit i = level i |
| mask_wr_en_i | input | 1 | Mask write strobe |
| mask_wr_data_i | input | 4 | Mask value to write |
| bus_sync_i | input | 1 | Sync strobe of the acknowledge access from the bus interface |
| pending_o | output | 1 | An unmasked request is pending |
| level_o | output | 2 | Selected level |
| ack_req_o | output | 1 | Request for an acknowledge access |
| iack_o | output | 1 | Acknowledge strobe, high with sync |
| dal_code_o | output | 4 | Code driven on the data lines |
| dal_oe_o | output | 1 | Drive enable for dal_code_o |
| mask_o | output | 4 | Current mask, 1 = level disabled |

## Verification
The assertions check on every cycle the following properties:
- The acknowledge request rises only after a phase-1 edge.
- The request holds until sync is seen.
- The held level does not move during an acknowledge.
- A finished acknowledge writes the code into the mask.
- A mask write lands on the next edge.
- The driven code always carries its top bit.
- The arbitration winner is the lowest-numbered live level.

Some behaviours can only be shown by the bench's scenarios. These are that a short pulse between sampling edges is never seen, the exact code for each level across mixed request and mask patterns, the collision of a mask write with the end of an acknowledge, and reset in the middle of an acknowledge.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_REQ  = 2'd1,
    SEQ_ACK  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/irq_sampler.sv
module irq_sampler #(
  parameter int NUM_LVL = 4,
  parameter int PHASES  = 4,
  localparam int PH_W   = (PHASES > 1) ? $clog2(PHASES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_LVL-1:0] irq_i,
  output logic [NUM_LVL-1:0] req_q,
  output logic [PH_W-1:0]    phase_o
);
  logic [PH_W-1:0] ph_q;

  // processor-cycle phase counter; phase 0 edge captures requests
  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q <= '0;
    end else if (ph_q == PH_W'(PHASES - 1)) begin
      ph_q <= '0;
    end else begin
      ph_q <= ph_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= '0;
    end else if (ph_q == '0) begin
      req_q <= irq_i;
    end
  end

  assign phase_o = ph_q;
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
  parameter int NUM_LVL = 4,
  localparam int LVL_W  = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1
) (
  input  logic [NUM_LVL-1:0] req_i,
  input  logic [NUM_LVL-1:0] mask_i,
  output logic [NUM_LVL-1:0] live_o,
  output logic               pend_o,
  output logic [LVL_W-1:0]   lvl_o
);
  assign live_o = req_i & ~mask_i;
  assign pend_o = |live_o;

  // scan from lowest priority upward so the lowest index wins
  always_comb begin
    lvl_o = '0;
    for (int i = NUM_LVL - 1; i >= 0; i--) begin
      if (live_o[i]) lvl_o = LVL_W'(i);
    end
  end
endmodule

// File: rtl/irq_code_gen.sv
module irq_code_gen #(
  parameter int NUM_LVL = 4,
  localparam int LVL_W  = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1
) (
  input  logic [LVL_W-1:0]   lvl_i,
  output logic [NUM_LVL-1:0] code_o
);
  // serviced level and every lower-priority level are disabled
  for (genvar g = 0; g < NUM_LVL; g++) begin : g_bit
    assign code_o[g] = (LVL_W'(g) >= lvl_i);
  end
endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
  import irq_pkg::*;
#(
  parameter int NUM_LVL = 4,
  parameter int PHASES  = 4,
  localparam int LVL_W  = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1,
  localparam int PH_W   = (PHASES > 1) ? $clog2(PHASES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PH_W-1:0]    phase_i,
  input  logic               pend_i,
  input  logic [LVL_W-1:0]   arb_lvl_i,
  input  logic               sync_i,
  input  logic               mask_wr_en_i,
  input  logic [NUM_LVL-1:0] mask_wr_data_i,
  input  logic [NUM_LVL-1:0] code_i,
  output logic [LVL_W-1:0]   lvl_o,
  output logic               ack_req_o,
  output logic               iack_o,
  output logic [NUM_LVL-1:0] mask_o
);
  seq_state_e         state_q;
  logic [LVL_W-1:0]   lvl_q;
  logic [NUM_LVL-1:0] mask_q;
  logic               decide;
  logic               start;
  logic               done;

  assign decide = (state_q == SEQ_IDLE) && (phase_i == PH_W'(1));
  assign start  = decide && pend_i;
  assign done   = (state_q == SEQ_ACK) && !sync_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
    end else begin
      unique case (state_q)
        SEQ_IDLE: if (start)   state_q <= SEQ_REQ;
        SEQ_REQ:  if (sync_i)  state_q <= SEQ_ACK;
        SEQ_ACK:  if (!sync_i) state_q <= SEQ_IDLE;
        default:               state_q <= SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= '0;
    end else if (decide) begin
      lvl_q <= arb_lvl_i;
    end
  end

  // acknowledge completion outranks a software write
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
    end else if (done) begin
      mask_q <= code_i;
    end else if (mask_wr_en_i) begin
      mask_q <= mask_wr_data_i;
    end
  end

  assign lvl_o     = lvl_q;
  assign ack_req_o = (state_q == SEQ_REQ);
  assign iack_o    = (state_q != SEQ_IDLE) && sync_i;
  assign mask_o    = mask_q;

  assert_req_holds_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == SEQ_REQ && !sync_i) |=> (state_q == SEQ_REQ));

  assert_level_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    (state_q != SEQ_IDLE) |=> $stable(lvl_q));

  assert_done_loads_code_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> (mask_q == $past(code_i)));

  assert_mask_write_R10: assert property (@(posedge clk) disable iff (rst)
    (mask_wr_en_i && !done) |=> (mask_q == $past(mask_wr_data_i)));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int NUM_LVL = 4,
  parameter int PHASES  = 4,
  localparam int LVL_W  = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1,
  localparam int PH_W   = (PHASES > 1) ? $clog2(PHASES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_LVL-1:0] irq_i,
  input  logic               mask_wr_en_i,
  input  logic [NUM_LVL-1:0] mask_wr_data_i,
  input  logic               bus_sync_i,
  output logic               pending_o,
  output logic [LVL_W-1:0]   level_o,
  output logic               ack_req_o,
  output logic               iack_o,
  output logic [NUM_LVL-1:0] dal_code_o,
  output logic               dal_oe_o,
  output logic [NUM_LVL-1:0] mask_o
);
  logic [NUM_LVL-1:0] req_q;
  logic [PH_W-1:0]    phase;
  logic [NUM_LVL-1:0] live;
  logic               arb_pend;
  logic [LVL_W-1:0]   arb_lvl;
  logic [LVL_W-1:0]   held_lvl;
  logic [NUM_LVL-1:0] code;
  logic [NUM_LVL-1:0] mask;

  irq_sampler #(.NUM_LVL(NUM_LVL), .PHASES(PHASES)) sampler_i (
    .clk     (clk),
    .rst     (rst),
    .irq_i   (irq_i),
    .req_q   (req_q),
    .phase_o (phase)
  );

  irq_prio_arb #(.NUM_LVL(NUM_LVL)) arb_i (
    .req_i  (req_q),
    .mask_i (mask),
    .live_o (live),
    .pend_o (arb_pend),
    .lvl_o  (arb_lvl)
  );

  irq_code_gen #(.NUM_LVL(NUM_LVL)) code_i (
    .lvl_i  (held_lvl),
    .code_o (code)
  );

  irq_ack_seq #(.NUM_LVL(NUM_LVL), .PHASES(PHASES)) seq_i (
    .clk            (clk),
    .rst            (rst),
    .phase_i        (phase),
    .pend_i         (arb_pend),
    .arb_lvl_i      (arb_lvl),
    .sync_i         (bus_sync_i),
    .mask_wr_en_i   (mask_wr_en_i),
    .mask_wr_data_i (mask_wr_data_i),
    .code_i         (code),
    .lvl_o          (held_lvl),
    .ack_req_o      (ack_req_o),
    .iack_o         (iack_o),
    .mask_o         (mask)
  );

  assign pending_o  = arb_pend;
  assign level_o    = held_lvl;
  assign dal_oe_o   = iack_o;
  assign dal_code_o = iack_o ? code : '0;
  assign mask_o     = mask;

  assert_start_phase_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_req_o) |-> ($past(phase) == PH_W'(1)));

  assert_winner_highest_R4: assert property (@(posedge clk) disable iff (rst)
    arb_pend |-> (live[arb_lvl] &&
                  ((live & ((NUM_LVL'(1) << arb_lvl) - NUM_LVL'(1))) == '0)));

  assert_code_top_bit_R7: assert property (@(posedge clk) disable iff (rst)
    dal_oe_o |-> (dal_code_o[NUM_LVL-1] && bus_sync_i));
endmodule

// File: tb/irq_prio_ctrl_tb_top.sv
module irq_prio_ctrl_tb_top;
  localparam int NL = 4;
  localparam int PH = 4;
  localparam int NV = 10;
  // {irq[3:0], mask[3:0], expected pending, expected level[1:0]}
  localparam logic [10:0] VEC [NV] = '{
    11'b0001_0000_1_00, 11'b1000_0000_1_11, 11'b0110_0000_1_01,
    11'b1111_0000_1_00, 11'b1111_0001_1_01, 11'b1100_0100_1_11,
    11'b1111_1111_0_00, 11'b0000_0000_0_00, 11'b1010_0010_1_11,
    11'b0101_0001_1_10
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NL-1:0] irq = '0;
  logic          mask_wr_en = 1'b0;
  logic [NL-1:0] mask_wr_data = '0;
  logic          sync = 1'b0;
  logic          pending_o, ack_req_o, iack_o, dal_oe_o;
  logic [1:0]    level_o;
  logic [NL-1:0] dal_code_o, mask_o;

  int n_cmp = 0;
  int n_bad = 0;
  int bph = 0;
  bit done_flag = 1'b0;
  logic [3:0] vi, vm;
  logic       vp;
  logic [1:0] vl;

  always #4 clk = ~clk;

  irq_prio_ctrl dut_i (
    .clk(clk), .rst(rst), .irq_i(irq), .mask_wr_en_i(mask_wr_en),
    .mask_wr_data_i(mask_wr_data), .bus_sync_i(sync), .pending_o(pending_o),
    .level_o(level_o), .ack_req_o(ack_req_o), .iack_o(iack_o),
    .dal_code_o(dal_code_o), .dal_oe_o(dal_oe_o), .mask_o(mask_o)
  );

  function automatic logic [3:0] code_of(int l);
    logic [3:0] c;
    for (int i = 0; i < 4; i++) c[i] = (i >= l);
    return c;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    bph = (bph + 1) % PH;
    #2;
  endtask

  // step until the edge just passed was phase p
  task automatic step_past(int p);
    do step(); while (bph != (p + 1) % PH);
  endtask

  task automatic write_mask(logic [3:0] m);
    mask_wr_en = 1'b1;
    mask_wr_data = m;
    step();
    mask_wr_en = 1'b0;
  endtask

  task automatic finish();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    bph = 0;
    // R1 reset state
    chk("R1 mask", mask_o, 4'b0000);
    chk("R1 pending", pending_o, 0);
    chk("R1 level", level_o, 0);
    chk("R1 ack_req", ack_req_o, 0);
    chk("R1 iack", iack_o, 0);
    chk("R1 oe", dal_oe_o, 0);

    for (int k = 0; k < NV; k++) begin
      vi = VEC[k][10:7];
      vm = VEC[k][6:3];
      vp = VEC[k][2];
      vl = VEC[k][1:0];
      irq = '0;
      step_past(0);
      write_mask(vm);
      chk("R10 mask load", mask_o, vm);
      irq = vi;
      step_past(0);
      chk("R3 pending", pending_o, vp);
      step_past(1);
      chk("R4 level", level_o, vl);
      chk("R5 ack request", ack_req_o, vp);
      chk("R12 no ack when blocked", ack_req_o & ~vp, 0);
      if (vp) begin
        step();
        chk("R5 request held", ack_req_o, 1);
        chk("R6 no iack before sync", iack_o, 0);
        irq = '0;
        sync = 1'b1;
        #1;
        chk("R6 iack with sync", iack_o, 1);
        chk("R7 oe", dal_oe_o, 1);
        chk("R7 code", dal_code_o, code_of(vl));
        step();
        sync = 1'b0;
        #1;
        chk("R6 iack drops with sync", iack_o, 0);
        chk("R7 code idle", dal_code_o, 0);
        step();
        chk("R8 mask from code", mask_o, code_of(vl));
        chk("R8 back to idle", ack_req_o, 0);
      end
    end

    // R2: pulse between sampling edges is never seen
    irq = '0;
    step_past(0);
    write_mask(4'b0000);
    step_past(0);
    irq = 4'b0001;
    step();
    chk("R2 pulse not sampled", pending_o, 0);
    step();
    irq = '0;
    step();
    step();
    chk("R2 pulse pending", pending_o, 0);
    step();
    chk("R2 pulse no ack", ack_req_o, 0);

    // R6: sync while idle is ignored
    sync = 1'b1;
    #1;
    chk("R6 idle sync iack", iack_o, 0);
    chk("R7 idle sync oe", dal_oe_o, 0);
    chk("R7 idle sync code", dal_code_o, 0);
    step();
    sync = 1'b0;
    chk("R6 idle sync no request", ack_req_o, 0);

    // R9 level hold, R11 write collides with ack end
    step_past(0);
    irq = 4'b0100;
    step_past(0);
    step_past(1);
    chk("R4 level 2", level_o, 2);
    chk("R5 start", ack_req_o, 1);
    irq = 4'b0001;
    step_past(0);
    chk("R3 higher request pending", pending_o, 1);
    step_past(1);
    chk("R9 level held", level_o, 2);
    chk("R9 still requesting", ack_req_o, 1);
    irq = '0;
    sync = 1'b1;
    step();
    sync = 1'b0;
    mask_wr_en = 1'b1;
    mask_wr_data = 4'b0000;
    step();
    mask_wr_en = 1'b0;
    chk("R11 code wins", mask_o, 4'b1100);

    // R10 timing of a mask write
    irq = 4'b0100;
    step_past(0);
    chk("R10 masked request", pending_o, 0);
    step();
    chk("R10 no ack while masked", ack_req_o, 0);
    write_mask(4'b0000);
    chk("R10 pending follows write", pending_o, 1);
    chk("R10 no start before phase 1", ack_req_o, 0);
    step_past(1);
    chk("R10 start at phase 1", ack_req_o, 1);
    irq = '0;
    sync = 1'b1;
    step();
    sync = 1'b0;
    step();
    chk("R8 mask level 2", mask_o, 4'b1100);

    // R1 reset in the middle of an acknowledge
    write_mask(4'b0000);
    irq = 4'b1000;
    step_past(0);
    step_past(1);
    chk("R5 start level 3", ack_req_o, 1);
    irq = '0;
    rst = 1'b1;
    step();
    rst = 1'b0;
    bph = 0;
    chk("R1 mid reset ack_req", ack_req_o, 0);
    chk("R1 mid reset mask", mask_o, 0);
    chk("R1 mid reset pending", pending_o, 0);
    chk("R1 mid reset level", level_o, 0);

    finish();
  end
endmodule